// File: doc/BRIEF.md
# Time-Domain Weighted Sum Oscillator

This block is a clocked digital model of an oscillator whose period carries the result of a multiply-accumulate. It has a set of binary inputs, and each input owns a small unsigned weight. While the run input is high, the block emits one single-cycle pulse per period. The length of each period, in clock cycles, is a fixed base count plus the sum of the weights of every input that is currently set. A larger weighted sum therefore gives a lower pulse rate. The result is read as an edge rate, not as a binary word.

Weights live in a register file beside the summation logic. Software fills it through a plain address, data and write-enable port before inference starts. The port is locked while the oscillator runs. Inputs are summed two at a time in paired cells, and the pair results are then added into a single total. A new period length is taken from the inputs only at a period boundary. A change to the inputs in the middle of a period therefore never cuts the pulse in progress short.

Top module: `wsum_period_osc`

## Requirements
- R1: After reset the spike output is low and every stored weight is 0, so with all inputs set the period equals BASE (4 by default).
- R2: While run is low, a write with wr_en high stores wr_data as the weight of input wr_addr; with only that input set, the period becomes BASE plus the stored weight.
- R3: A write attempted while run is high leaves the stored weight unchanged.
- R4: While run stays high, consecutive spike pulses are exactly P clock cycles apart, where P = BASE + sum over i of w_i when x[i] is 1.
- R5: The first spike is driven by the clock edge that comes P cycles after the first edge at which run is sampled high.
- R6: The inputs are sampled only at the start edge and at each spike edge; a change between two such edges does not alter the period in progress, and it takes effect from the next period.
- R7: Each spike lasts exactly one cycle whenever P is greater than 1.
- R8: After an edge that samples run low, spike stays low until run is raised again, and a restart begins a fresh period as in R5.
- R9: With every weight at its maximum of 7 and every input set, the period is BASE + 7·N_IN (900 by default) with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables oscillation; also locks the weight port |
| x | input | N_IN | Binary inputs, bit i selects weight i |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | $clog2(N_IN) | Index of the weight to write |
| wr_data | input | W_BITS | Unsigned weight value |
| spike | output | 1 | One-cycle pulse at the end of each period |

## Verification
The assertions assume that run and x change only between clock edges, and that wr_addr always names an existing input. The period counter and its bounds are checked on that basis. The bench drives every input on the falling edge and addresses only inputs inside the array. It attempts a weight write while running only in the scenario that tests the lock. Changes to the inputs in mid-period are made right after a spike is seen, so the period in progress is known exactly.

// File: rtl/wsum_period_osc.sv
module wsum_period_osc #(
  parameter int N_IN   = 128,
  parameter int W_BITS = 3,
  parameter int BASE   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [N_IN-1:0]         x,
  input  logic                    wr_en,
  input  logic [$clog2(N_IN)-1:0] wr_addr,
  input  logic [W_BITS-1:0]       wr_data,
  output logic                    spike
);
  localparam int A_W   = $clog2(N_IN);
  localparam int WMAX  = (1 << W_BITS) - 1;
  localparam int P_W   = $clog2(N_IN * WMAX + BASE + 1);
  localparam int NPAIR = N_IN / 2;

  logic [W_BITS-1:0] wt [N_IN];
  logic [W_BITS:0]   psum [NPAIR];
  logic [P_W-1:0]    tot, next_per, per, cnt;
  logic              active, spike_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) wt[i] <= '0;
    end else if (wr_en && !run) begin
      wt[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign psum[g] = (x[2*g]   ? {1'b0, wt[2*g]}   : '0)
                   + (x[2*g+1] ? {1'b0, wt[2*g+1]} : '0);
  end

  always_comb begin
    tot = '0;
    for (int p = 0; p < NPAIR; p++) tot = tot + P_W'(psum[p]);
  end

  assign next_per = tot + P_W'(BASE);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active  <= 1'b0;
      cnt     <= '0;
      per     <= '0;
      spike_q <= 1'b0;
    end else if (!active) begin
      active  <= 1'b1;
      cnt     <= P_W'(1);
      per     <= next_per;
      spike_q <= 1'b0;
    end else if (cnt == per) begin
      cnt     <= P_W'(1);
      per     <= next_per;
      spike_q <= 1'b1;
    end else begin
      cnt     <= cnt + P_W'(1);
      spike_q <= 1'b0;
    end
  end

  assign spike = spike_q;

  // R8: a pulse only follows an edge that sampled run high
  a_r8_spike_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> $past(run));

  // R7: single-cycle pulse when the period exceeds one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (spike && per > P_W'(1) && run) |=> !spike);

  // R3: locked weight port
  a_r3_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> wt[$past(wr_addr)] == $past(wt[wr_addr]));

  // R4: position inside the period stays within 1..per
  a_r4_cnt_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt >= P_W'(1) && cnt <= per && per >= P_W'(BASE)));

  // R6: period length frozen between boundaries
  a_r6_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run && cnt != per) |=> $stable(per));

  initial begin
    a_r9_no_wrap: assert (N_IN * WMAX + BASE < (1 << P_W));
  end
endmodule

// File: tb/tb_wsum_period_osc.sv
module tb_wsum_period_osc;
  localparam int CLK_NS = 10;
  localparam int N_IN = 128;
  localparam int W_BITS = 3;
  localparam int BASE = 4;

  logic clk = 0, rst_n = 0, run = 0, wr_en = 0, spike;
  logic [N_IN-1:0] x = '0;
  logic [6:0] wr_addr = '0;
  logic [W_BITS-1:0] wr_data = '0;

  int errors = 0, checks = 0, cyc = 0;
  int mw [N_IN];

  wsum_period_osc #(.N_IN(N_IN), .W_BITS(W_BITS), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .x(x), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .spike(spike));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_per(logic [N_IN-1:0] xv);
    int s = BASE;
    for (int i = 0; i < N_IN; i++) if (xv[i]) s += mw[i];
    return s;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 7'(a); wr_data = W_BITS'(d);
    if (!run) mw[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_spike(output int k, input int lim, input bit chk_gap, input string tag);
    k = 0;
    while (k < lim) begin
      @(negedge clk);
      k++;
      if (k == 1 && chk_gap && lim > 3) chk({tag, " R7 pulse width"}, int'(spike), 0);
      if (spike) break;
    end
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 0;
    @(negedge clk);
  endtask

  task automatic measure(logic [N_IN-1:0] xv, int n_int, string tag);
    int p, k;
    p = exp_per(xv);
    @(negedge clk);
    x = xv; run = 1;
    wait_spike(k, p + 5, 0, tag);
    chk({tag, " R5 first latency"}, k - 1, p);
    for (int j = 0; j < n_int; j++) begin
      wait_spike(k, p + 5, p > 1, tag);
      chk({tag, " R4 interval"}, k, p);
    end
    stop_run();
  endtask

  task automatic t_reset();
    int k;
    chk("R1 spike low after reset", int'(spike), 0);
    measure('1, 2, "R1 zero weights");
  endtask

  task automatic t_load();
    for (int i = 0; i < N_IN; i++) wr(i, (i * 5 + 3) % 8);
    measure(N_IN'(1) << 9, 1, "R2 single input 9");
    measure(N_IN'(1) << 127, 1, "R2 single input 127");
    measure({64{2'b10}}, 2, "R4 odd inputs");
    measure({32{4'b0011}}, 2, "R4 pattern 0011");
  endtask

  task automatic t_locked();
    int old5, k;
    old5 = mw[5];
    @(negedge clk);
    x = '0; run = 1;
    wr(5, (old5 + 3) % 8);
    wait_spike(k, BASE + 5, 0, "R3");
    wait_spike(k, BASE + 5, 1, "R3");
    chk("R3 period unchanged while locked", k, BASE);
    stop_run();
    measure(N_IN'(1) << 5, 1, "R3 weight kept");
  endtask

  task automatic t_midchange();
    logic [N_IN-1:0] a, b;
    int pa, pb, k;
    a = {16{8'hF0}};
    b = {16{8'h01}};
    pa = exp_per(a); pb = exp_per(b);
    @(negedge clk);
    x = a; run = 1;
    wait_spike(k, pa + 5, 0, "R6");
    x = b;
    wait_spike(k, pa + 5, 1, "R6");
    chk("R6 current period kept", k, pa);
    wait_spike(k, pb + 5, 1, "R6");
    chk("R6 new period applied", k, pb);
    x = a;
    repeat (2) @(negedge clk);
    x = b;
    wait_spike(k, pb + 5, 0, "R6");
    chk("R6 glitch mid-period ignored", k, pb - 2);
    stop_run();
  endtask

  task automatic t_stop();
    int seen = 0;
    @(negedge clk);
    x = '1; run = 1;
    repeat (3 * exp_per('1)) @(negedge clk);
    run = 0;
    @(negedge clk);
    repeat (2000) begin
      if (spike) seen++;
      @(negedge clk);
    end
    chk("R8 no spike while stopped", seen, 0);
    measure({64{2'b01}}, 1, "R8 fresh restart");
  endtask

  task automatic t_max();
    for (int i = 0; i < N_IN; i++) wr(i, 7);
    chk("R9 model max period", exp_per('1), BASE + 7 * N_IN);
    measure('1, 2, "R9 full scale");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N_IN; i++) mw[i] = 0;
    t_reset();
    t_load();
    t_locked();
    t_midchange();
    t_stop();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule